// File: doc/BRIEF.md
# Standby State Controller

This block moves a small system-on-chip between full operation and a static standby state. A sleep request, honoured only when no enabled wake interrupt is pending, drops the run indication. While run is low the external address and data buses are driven to zero, internal peripherals are held in reset, the PLL is switched off in PLL clock mode, and the external oscillator clock-enable may be pulled low in the 13 MHz clock mode.

An enabled external interrupt wakes the system. The block then waits for the clock source to settle. It counts ticks of the always-on 32.768 kHz domain, which reach it as a one-cycle strobe. The wait is short when the external oscillator was kept running and long otherwise. Interrupts seen while asleep or settling are captured in sticky flags that survive the return to run. Software clears them with an acknowledge, and while any flag is set the block refuses another sleep request.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, run is 1, periph_rst is 0, wake_src is all zero, and the controller is in the running state.
- R2: In the running state, sleep_req takes the block to standby at the next clock edge only if (irq_in & irq_en) is zero and wake_src is zero. Otherwise run stays 1.
- R3: While run is 0, addr_out and data_out are all zero. While run is 1, they equal addr_in and data_in.
- R4: periph_rst is 1 exactly while run is 0. It falls in the same cycle that run rises.
- R5: With pll_mode=1 (PLL clock mode), pll_en is 0 in standby and 1 otherwise, including during settling. With pll_mode=0 (13 MHz mode), pll_en is always 0.
- R6: clken is 0 only in standby with pll_mode=0 and osc_keep=0. Otherwise it is 1.
- R7: In standby, an interrupt line whose irq_en bit is 0 has no effect: run stays 0 and its wake_src bit stays 0. An enabled line that is high starts settling at the next edge.
- R8: The settling wait is SHORT_TICKS slow_tick strobes (default 16) when pll_mode=0 and osc_keep=1, and LONG_TICKS strobes (default 8192) otherwise. The choice is made on the wake edge. run rises at the edge that takes the last strobe.
- R9: Any enabled interrupt seen high in standby or settling sets its wake_src bit. The bit stays set until wake_ack is high in the running state, including an interrupt that arrives on the final settling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle strobe per 32.768 kHz period |
| sleep_req | input | 1 | Request to enter standby |
| wake_ack | input | 1 | Clears wake_src while running |
| pll_mode | input | 1 | 1 = PLL clock mode, 0 = 13 MHz mode |
| osc_keep | input | 1 | 13 MHz mode: keep external oscillator enabled in standby |
| irq_in | input | NUM_IRQ | External wake interrupt lines, active high |
| irq_en | input | NUM_IRQ | Per-line wake enable |
| addr_in | input | ADDR_W | Address from the bus master |
| data_in | input | DATA_W | Write data from the bus master |
| run | output | 1 | High while the system is running |
| periph_rst | output | 1 | Holds internal peripherals in reset |
| pll_en | output | 1 | PLL enable |
| clken | output | 1 | External oscillator clock-enable |
| addr_out | output | ADDR_W | Gated external address bus |
| data_out | output | DATA_W | Gated external data bus |
| wake_src | output | NUM_IRQ | Sticky wake-source flags |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the final settling strobe and a fresh interrupt on a different line: the bench raises that line in the exact cycle the last strobe is taken. Run must rise at that edge, and the new wake_src bit must still be set afterwards. The second pair is wake_ack and sleep_req asserted together while a flag is set. The acknowledge must clear the flags, and the sleep request must be refused because it sees the flags as they were before the clear. A behavioural model in the bench predicts every output each cycle, and the comparison is made in the middle of the high phase.

// File: rtl/standby_pkg.sv
package standby_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_SLEEP  = 2'd1,
      ST_SETTLE = 2'd2
   } stby_state_e;

   function automatic logic short_wait(input logic pll_mode, input logic osc_keep);
      return (!pll_mode) && osc_keep;
   endfunction

endpackage

// File: rtl/stby_wake_latch.sv
module stby_wake_latch #(
   parameter int NUM_IRQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic               clear,
   input  logic [NUM_IRQ-1:0] irq_in,
   input  logic [NUM_IRQ-1:0] irq_en,
   output logic               any_pending,
   output logic               any_latched,
   output logic [NUM_IRQ-1:0] flags
);

   logic [NUM_IRQ-1:0] pend;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      assign pend[i] = irq_in[i] & irq_en[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 flags[i] <= 1'b0;
         else if (clear)             flags[i] <= 1'b0;
         else if (capture && pend[i]) flags[i] <= 1'b1;
      end
   end

   assign any_pending = |pend;
   assign any_latched = |flags;

endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer #(
   parameter int LONG_TICKS  = 8192,
   parameter int SHORT_TICKS = 16,
   localparam int CW = $clog2(LONG_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic use_short,
   input  logic active,
   input  logic tick,
   output logic done
);

   localparam logic [CW-1:0] LONG_V  = CW'(LONG_TICKS);
   localparam logic [CW-1:0] SHORT_V = CW'(SHORT_TICKS);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (load)                       cnt <= use_short ? SHORT_V : LONG_V;
      else if (active && tick && cnt != '0) cnt <= cnt - 1'b1;
   end

   assign done = active && tick && (cnt == CW'(1));

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
   import standby_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sleep_req,
   input  logic        any_pending,
   input  logic        any_latched,
   input  logic        settle_done,
   output stby_state_e state
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_RUN;
      else begin
         case (state)
            ST_RUN:    if (sleep_req && !any_pending && !any_latched) state <= ST_SLEEP;
            ST_SLEEP:  if (any_pending) state <= ST_SETTLE;
            ST_SETTLE: if (settle_done) state <= ST_RUN;
            default:   state <= ST_RUN;
         endcase
      end
   end

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
   import standby_pkg::*;
#(
   parameter int NUM_IRQ     = 4,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int LONG_TICKS  = 8192,
   parameter int SHORT_TICKS = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               slow_tick,
   input  logic               sleep_req,
   input  logic               wake_ack,
   input  logic               pll_mode,
   input  logic               osc_keep,
   input  logic [NUM_IRQ-1:0] irq_in,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic [ADDR_W-1:0]  addr_in,
   input  logic [DATA_W-1:0]  data_in,
   output logic               run,
   output logic               periph_rst,
   output logic               pll_en,
   output logic               clken,
   output logic [ADDR_W-1:0]  addr_out,
   output logic [DATA_W-1:0]  data_out,
   output logic [NUM_IRQ-1:0] wake_src
);

   if (NUM_IRQ < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("standby_ctrl: widths must be at least 1");
   end
   if (SHORT_TICKS < 1 || SHORT_TICKS >= LONG_TICKS) begin : g_bad_ticks
      $error("standby_ctrl: need 1 <= SHORT_TICKS < LONG_TICKS");
   end

   stby_state_e state;
   logic        any_pending, any_latched, settle_done;
   logic        in_run, in_sleep;

   assign in_run   = (state == ST_RUN);
   assign in_sleep = (state == ST_SLEEP);

   stby_wake_latch #(.NUM_IRQ(NUM_IRQ)) u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture     (!in_run),
      .clear       (in_run && wake_ack),
      .irq_in      (irq_in),
      .irq_en      (irq_en),
      .any_pending (any_pending),
      .any_latched (any_latched),
      .flags       (wake_src)
   );

   stby_settle_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (in_sleep && any_pending),
      .use_short (short_wait(pll_mode, osc_keep)),
      .active    (state == ST_SETTLE),
      .tick      (slow_tick),
      .done      (settle_done)
   );

   stby_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_req),
      .any_pending (any_pending),
      .any_latched (any_latched),
      .settle_done (settle_done),
      .state       (state)
   );

   assign run        = in_run;
   assign periph_rst = !in_run;
   assign pll_en     = pll_mode && !in_sleep;
   assign clken      = !(in_sleep && !pll_mode && !osc_keep);

   for (genvar a = 0; a < ADDR_W; a++) begin : g_addr_gate
      assign addr_out[a] = addr_in[a] & in_run;
   end
   for (genvar d = 0; d < DATA_W; d++) begin : g_data_gate
      assign data_out[d] = data_in[d] & in_run;
   end

endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk #(
   parameter int NUM_IRQ = 4,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               slow_tick,
   input logic               pll_mode,
   input logic [NUM_IRQ-1:0] irq_in,
   input logic [NUM_IRQ-1:0] irq_en,
   input logic               run,
   input logic               periph_rst,
   input logic               pll_en,
   input logic               clken,
   input logic [ADDR_W-1:0]  addr_out,
   input logic [DATA_W-1:0]  data_out,
   input logic [NUM_IRQ-1:0] wake_src
);

   AST_SLEEP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (|(irq_in & irq_en))) |=> run); // R2
   AST_BUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (addr_out == '0 && data_out == '0)); // R3
   AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $fell(periph_rst)); // R4
   AST_PLL_OFF_13M: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_mode |-> !pll_en); // R5
   AST_CLKEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !clken |-> (!run && !pll_en)); // R6
   AST_RUN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(slow_tick)); // R8
   AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && (|wake_src)) |=> (|wake_src)); // R9

endmodule

bind standby_ctrl standby_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slow_tick  (slow_tick),
   .pll_mode   (pll_mode),
   .irq_in     (irq_in),
   .irq_en     (irq_en),
   .run        (run),
   .periph_rst (periph_rst),
   .pll_en     (pll_en),
   .clken      (clken),
   .addr_out   (addr_out),
   .data_out   (data_out),
   .wake_src   (wake_src)
);

// File: tb/tb_standby_ctrl.sv
`timescale 1ns/1ps
module tb_standby_ctrl;

   localparam int N = 4, AW = 16, DW = 32, LONG = 8192, SHORT = 16;

   logic clk = 0, rst_n = 0, slow_tick = 0, sleep_req = 0, wake_ack = 0;
   logic pll_mode = 1, osc_keep = 0;
   logic [N-1:0] irq_in = '0, irq_en = '0;
   logic [AW-1:0] addr_in = 16'hBEEF;
   logic [DW-1:0] data_in = 32'hCAFE1234;
   logic run, periph_rst, pll_en, clken;
   logic [AW-1:0] addr_out;
   logic [DW-1:0] data_out;
   logic [N-1:0] wake_src;

   int total = 0, bad = 0;
   int m_st = 0, m_cnt = 0;
   logic [N-1:0] m_wk = '0;
   bit tick_run = 0;

   standby_ctrl #(.NUM_IRQ(N), .ADDR_W(AW), .DATA_W(DW), .LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) dut (.*);

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // reference model: state 0 run, 1 standby, 2 settling
   always @(posedge clk or negedge rst_n) begin
      logic [N-1:0] pend;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_wk = '0;
      end else begin
         pend = irq_in & irq_en;
         case (m_st)
            0: begin
               if (sleep_req && pend == 0 && m_wk == 0) m_st = 1;
               if (wake_ack) m_wk = '0;
            end
            1: begin
               m_wk = m_wk | pend;
               if (pend != 0) begin
                  m_st = 2;
                  m_cnt = (!pll_mode && osc_keep) ? SHORT : LONG;
               end
            end
            default: begin
               m_wk = m_wk | pend;
               if (slow_tick) begin
                  if (m_cnt == 1) m_st = 0;
                  m_cnt = m_cnt - 1;
               end
            end
         endcase
      end
   end

   always @(posedge clk) begin
      bit e_run;
      #5;
      e_run = (m_st == 0);
      check(run == e_run, "R2,R7,R8 run", run, e_run);
      check(periph_rst == !e_run, "R4 periph_rst", periph_rst, !e_run);
      check(pll_en == (pll_mode && m_st != 1), "R5 pll_en", pll_en, pll_mode && m_st != 1);
      check(clken == !(m_st == 1 && !pll_mode && !osc_keep), "R6 clken", clken,
            !(m_st == 1 && !pll_mode && !osc_keep));
      check(addr_out == (e_run ? addr_in : '0), "R3 addr_out", addr_out, e_run ? addr_in : 0);
      check(data_out == (e_run ? data_in : '0), "R3 data_out", data_out, e_run ? data_in : 0);
      check(wake_src == m_wk, "R9 wake_src", wake_src, m_wk);
   end

   initial begin
      forever begin
         @(negedge clk);
         slow_tick = tick_run ? ~slow_tick : 1'b0;
      end
   end

   initial begin
      #(20 * 200000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_run();
      while (run !== 1'b1) @(negedge clk);
   endtask

   initial begin
      cyc(3);
      check(run == 1 && periph_rst == 0 && wake_src == 0, "R1 reset", {run, periph_rst}, 2'b10);
      rst_n = 1;
      tick_run = 1;
      cyc(2);
      // R2: sleep refused while enabled interrupt pending
      irq_en = 4'b0011; irq_in = 4'b0001; sleep_req = 1;
      cyc(2);
      check(run == 1, "R2 sleep blocked", run, 1);
      irq_in = 0; cyc(1); sleep_req = 0; cyc(2);
      check(run == 0, "R2 sleep taken", run, 0);
      // R7: disabled line ignored
      irq_in = 4'b1100; cyc(6);
      check(run == 0 && wake_src == 0, "R7 disabled irq ignored", {run, wake_src}, 0);
      // R8 short wait in 13 MHz mode with oscillator kept
      pll_mode = 0; osc_keep = 1; irq_in = 4'b0010; cyc(1); irq_in = 0;
      wait_run();
      check(wake_src == 4'b0010, "R9 flag after wake", wake_src, 4'b0010);
      // R9: ack and sleep in same cycle -> refused, flags cleared
      sleep_req = 1; wake_ack = 1; cyc(1); wake_ack = 0; sleep_req = 0; cyc(1);
      check(run == 1 && wake_src == 0, "R9 ack with sleep", {run, wake_src}, 2'b10);
      // R6: 13 MHz, oscillator off, long wait
      osc_keep = 0; sleep_req = 1; cyc(1); sleep_req = 0; cyc(2);
      check(clken == 0, "R6 clken low", clken, 0);
      irq_in = 4'b0001; cyc(1); irq_in = 0;
      // new interrupt exactly on the final settling edge (R9)
      while (!(dut.run === 1'b0 && m_st == 2 && m_cnt == 1 && slow_tick == 1)) @(negedge clk);
      irq_in = 4'b0010; cyc(1); irq_in = 0;
      check(run == 1 && wake_src == 4'b0011, "R9 irq on last tick", wake_src, 4'b0011);
      wake_ack = 1; cyc(1); wake_ack = 0;
      // R5: PLL mode, osc_keep set does not shorten the wait
      pll_mode = 1; osc_keep = 1; sleep_req = 1; cyc(1); sleep_req = 0; cyc(2);
      check(pll_en == 0, "R5 pll off in standby", pll_en, 0);
      irq_in = 4'b0001; cyc(1); irq_in = 0; cyc(40);
      check(run == 0 && pll_en == 1, "R8 long wait in PLL mode", {run, pll_en}, 2'b01);
      wait_run();
      cyc(3);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule